// File: doc/BRIEF.md
# Secondary Interrupt Controller with Pass-Through

This block collects 32 level-sensitive interrupt sources in front of a primary interrupt controller. On every clock it captures the level of each source into a raw level register. It masks the raw levels with a per-source enable register and reduces the result to one summary request on output line 31. A limited band of sources, 21 to 30 by default, can also be routed one-to-one onto the primary input with the same index. Each of these routes has its own pass-through enable bit.

Software reaches the state through a single-cycle APB-style port that decodes a 4 KB window. Word-indexed offsets (byte offset shifted right by two) select the registers. Enables change only through separate set and clear words, so no read-modify-write is needed. All interrupt outputs are registered. An output reflects the register state one clock edge after that state changes. A change on a source pin therefore reaches its output on the second rising edge after it is driven.

Top module: `sec_irq_ctrl`

## Requirements
- R1: The raw level register loads `src_i` on every rising edge. A read of word 1 (byte 0x04) returns it.
- R2: `irq_o[31]` is high exactly when (raw AND enable) is nonzero. It updates on the edge after raw or enable changes, never on the same edge.
- R3: A read of word 0 (byte 0x00) returns raw AND enable. A read of word 2 (byte 0x08) returns the enable register.
- R4: A write to word 2 (0x08) ORs `pwdata` into the enable register. A write to word 3 (0x0C) clears every enable bit where `pwdata` is 1.
- R5: A read of word 4 (0x10) returns raw bit 0 in bit 0 and zeros elsewhere. Any nonzero write to word 4 sets enable bit 0 and a nonzero write to word 5 (0x14) clears it. Zero writes to either word change nothing.
- R6: A read of word 8 (0x20) returns the pass-through enable. A write to word 8 ORs in `pwdata & 0x7FE00000`, so only bits 21..30 can ever be set. A write to word 9 (0x24) clears the bits where `pwdata` is 1.
- R7: For i in 21..30, `irq_o[i]` equals (pass-through bit i AND raw bit i), one edge after either changes. It is low whenever its pass-through bit is clear.
- R8: `irq_o[20:0]` is always zero. Bit 31 carries only the summary and can never be placed in pass-through.
- R9: Reads of undefined words (3, 5, 6, 7, 9 and 10..1023) return zero. Writes to undefined words, and to read-only words 0 and 1, change no register and no output.
- R10: A synchronous active-high `rst` clears raw, enable, pass-through and all outputs.
- R11: A write commits only on a cycle with `psel`, `penable` and `pwrite` all high. A setup phase alone has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for capture, registers and outputs |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset inside the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while `psel` is high and `pwrite` is low |
| irq_o | output | 32 | Primary interrupt lines: bit 31 is the summary, bits 21..30 are pass-through, the rest stay low |

## Verification
The bench uses the default parameters: 32 sources, a pass-through band of 21 to 30 and a 12-bit byte address. With these values the summary line, both edges of the pass-through band (20/21 and 30/31) and the far corner of the decode window (word 1023) are all reachable through the normal port. Each scenario starts from reset. Outputs are sampled one edge before and one edge after each change, which pins down the single-register latency of every output path.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // Word indices (byte offset >> 2) inside the register window
  localparam int unsigned RW_STATUS  = 0;
  localparam int unsigned RW_RAW     = 1;
  localparam int unsigned RW_EN_SET  = 2;
  localparam int unsigned RW_EN_CLR  = 3;
  localparam int unsigned RW_B0_SET  = 4;
  localparam int unsigned RW_B0_CLR  = 5;
  localparam int unsigned RW_PT_SET  = 8;
  localparam int unsigned RW_PT_CLR  = 9;
endpackage

// File: rtl/sic_regfile.sv
module sic_regfile #(
  parameter int DW     = 32,
  parameter int AW     = 12,
  parameter int PT_LO  = 21,
  parameter int PT_HI  = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] src_i,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic [DW-1:0] raw_q,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] pt_q
);
  import sic_pkg::*;

  localparam int WW = AW - 2;
  localparam logic [WW-1:0] K_STATUS = WW'(RW_STATUS);
  localparam logic [WW-1:0] K_RAW    = WW'(RW_RAW);
  localparam logic [WW-1:0] K_EN_SET = WW'(RW_EN_SET);
  localparam logic [WW-1:0] K_EN_CLR = WW'(RW_EN_CLR);
  localparam logic [WW-1:0] K_B0_SET = WW'(RW_B0_SET);
  localparam logic [WW-1:0] K_B0_CLR = WW'(RW_B0_CLR);
  localparam logic [WW-1:0] K_PT_SET = WW'(RW_PT_SET);
  localparam logic [WW-1:0] K_PT_CLR = WW'(RW_PT_CLR);
  localparam logic [DW-1:0] PT_MASK  =
    DW'(((64'd1 << (PT_HI - PT_LO + 1)) - 64'd1) << PT_LO);
  localparam logic [DW-1:0] BIT0     = DW'(1);

  logic [WW-1:0] word;
  logic          wr_go;
  logic          wd_nz;

  assign word  = paddr[AW-1:2];
  assign wr_go = psel & penable & pwrite;
  assign wd_nz = |pwdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      en_q  <= '0;
      pt_q  <= '0;
    end else begin
      raw_q <= src_i;
      if (wr_go) begin
        case (word)
          K_EN_SET: en_q <= en_q | pwdata;
          K_EN_CLR: en_q <= en_q & ~pwdata;
          K_B0_SET: if (wd_nz) en_q <= en_q | BIT0;
          K_B0_CLR: if (wd_nz) en_q <= en_q & ~BIT0;
          K_PT_SET: pt_q <= pt_q | (pwdata & PT_MASK);
          K_PT_CLR: pt_q <= pt_q & ~pwdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (word)
        K_STATUS: prdata = raw_q & en_q;
        K_RAW:    prdata = raw_q;
        K_EN_SET: prdata = en_q;
        K_B0_SET: prdata = {{(DW-1){1'b0}}, raw_q[0]};
        K_PT_SET: prdata = pt_q;
        default:  prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sic_irq_out.sv
module sic_irq_out #(
  parameter int DW    = 32,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] raw_q,
  input  logic [DW-1:0] en_q,
  input  logic [DW-1:0] pt_q,
  output logic [DW-1:0] irq_q
);
  localparam int SUM_IDX = DW - 1;

  logic [DW-1:0] nxt;

  for (genvar i = 0; i < DW; i++) begin : g_line
    if (i == SUM_IDX) begin : g_sum
      assign nxt[i] = |(raw_q & en_q);
    end else if (i >= PT_LO && i <= PT_HI) begin : g_pt
      assign nxt[i] = raw_q[i] & pt_q[i];
    end else begin : g_off
      assign nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= nxt;
  end
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl #(
  parameter int NSRC  = 32,
  parameter int AW    = 12,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [AW-1:0]   paddr,
  input  logic [NSRC-1:0] pwdata,
  output logic [NSRC-1:0] prdata,
  output logic [NSRC-1:0] irq_o
);
  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] pt_q;

  sic_regfile #(.DW(NSRC), .AW(AW), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_regs (
    .clk(clk), .rst(rst), .src_i(src_i),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .raw_q(raw_q), .en_q(en_q), .pt_q(pt_q)
  );

  sic_irq_out #(.DW(NSRC), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_out (
    .clk(clk), .rst(rst),
    .raw_q(raw_q), .en_q(en_q), .pt_q(pt_q),
    .irq_q(irq_o)
  );
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int NSRC  = 32,
  parameter int AW    = 12,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_i,
  input logic            psel,
  input logic            penable,
  input logic            pwrite,
  input logic [AW-1:0]   paddr,
  input logic [NSRC-1:0] pwdata,
  input logic [NSRC-1:0] irq_o,
  input logic [NSRC-1:0] raw_q,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] pt_q
);
  localparam int SUM = NSRC - 1;
  localparam logic [NSRC-1:0] PT_MASK =
    NSRC'(((64'd1 << (PT_HI - PT_LO + 1)) - 64'd1) << PT_LO);

  logic ok;
  logic wr_go;
  always_ff @(posedge clk) begin
    if (rst) ok <= 1'b0;
    else     ok <= 1'b1;
  end
  assign wr_go = psel && penable && pwrite;

  p_raw_follow_r1: assert property (@(posedge clk) disable iff (rst)
    ok |-> raw_q == $past(src_i));

  p_summary_r2: assert property (@(posedge clk) disable iff (rst)
    ok |-> irq_o[SUM] == $past(|(raw_q & en_q)));

  p_enset_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_go && paddr[AW-1:2] == (AW-2)'(2)) |=> en_q == ($past(en_q) | $past(pwdata)));

  p_pt_range_r6: assert property (@(posedge clk) disable iff (rst)
    (pt_q & ~PT_MASK) == '0);

  for (genvar i = PT_LO; i <= PT_HI; i++) begin : g_pt_chk
    p_pt_follow_r7: assert property (@(posedge clk) disable iff (rst)
      ok |-> irq_o[i] == $past(raw_q[i] & pt_q[i]));
  end

  p_low_lines_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o[PT_LO-1:0] == '0);

  p_undef_write_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_go && paddr[AW-1:2] == (AW-2)'(6)) |=> $stable(en_q) && $stable(pt_q));
endmodule

bind sec_irq_ctrl sic_checker #(.NSRC(NSRC), .AW(AW), .PT_LO(PT_LO), .PT_HI(PT_HI)) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .irq_o(irq_o),
  .raw_q(raw_q), .en_q(en_q), .pt_q(pt_q)
);

// File: tb/tb_sec_irq_ctrl.sv
module tb_sec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_i = '0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  sec_irq_ctrl dut (
    .clk(clk), .rst(rst), .src_i(src_i), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int word, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = 12'(word << 2); pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input int word, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = 12'(word << 2);
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; src_i = '0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk); src_i = 32'hFFFF_FFFF;
    do_reset();
    chk("R10 irq after reset", irq_o, 32'h0);
    rd(1, d); chk("R10 raw after reset", d, 32'h0);
    rd(2, d); chk("R10 enable after reset", d, 32'h0);
    rd(8, d); chk("R10 pass-through after reset", d, 32'h0);
  endtask

  task automatic t_raw();
    logic [31:0] d;
    do_reset();
    src_i = 32'hA5A5_0F0F;
    rd(1, d); chk("R1 raw read pattern A", d, 32'hA5A5_0F0F);
    src_i = 32'h5A5A_F0F0;
    rd(1, d); chk("R1 raw read pattern B", d, 32'h5A5A_F0F0);
  endtask

  task automatic t_summary();
    logic [31:0] d;
    do_reset();
    src_i = 32'h0000_0100;
    wr(2, 32'h0000_0300);
    chk("R2 summary not yet updated on commit edge", irq_o, 32'h0);
    @(negedge clk);
    chk("R2 summary one edge after enable", irq_o, 32'h8000_0000);
    rd(0, d); chk("R3 masked status", d, 32'h0000_0100);
    rd(2, d); chk("R3 enable read", d, 32'h0000_0300);
    wr(3, 32'h0000_0100);
    rd(2, d); chk("R4 enable after clear", d, 32'h0000_0200);
    chk("R2 summary drops after clear", irq_o, 32'h0);
    wr(2, 32'h0001_0000);
    rd(2, d); chk("R4 enable OR set", d, 32'h0001_0200);
    @(negedge clk); src_i = 32'h0000_0200;
    @(negedge clk);
    chk("R2 summary lags source by two edges", irq_o, 32'h0);
    @(negedge clk);
    chk("R2 summary follows source", irq_o, 32'h8000_0000);
  endtask

  task automatic t_bit0();
    logic [31:0] d;
    do_reset();
    src_i = 32'h0000_0003;
    rd(4, d); chk("R5 word4 read only bit0", d, 32'h1);
    wr(4, 32'h0);
    rd(2, d); chk("R5 zero write to word4 ignored", d, 32'h0);
    wr(4, 32'h8000_0000);
    rd(2, d); chk("R5 nonzero write sets bit0", d, 32'h1);
    chk("R5 summary from bit0", irq_o, 32'h8000_0000);
    wr(5, 32'h0);
    rd(2, d); chk("R5 zero write to word5 ignored", d, 32'h1);
    wr(5, 32'h0000_0040);
    rd(2, d); chk("R5 nonzero write clears bit0", d, 32'h0);
  endtask

  task automatic t_passthru();
    logic [31:0] d;
    do_reset();
    src_i = 32'hFFFF_FFFF;
    wr(8, 32'hFFFF_FFFF);
    rd(8, d); chk("R6 pass-through set masked", d, 32'h7FE0_0000);
    chk("R7 pass-through lines follow", irq_o, 32'h7FE0_0000);
    @(negedge clk); src_i = 32'hFDFF_FFFF;
    @(negedge clk);
    chk("R7 line 25 one edge after change", irq_o, 32'h7FE0_0000);
    @(negedge clk);
    chk("R7 line 25 forwarded low", irq_o, 32'h7DE0_0000);
    src_i = 32'hFFFF_FFFF;
    wr(9, 32'h0240_0000);
    @(negedge clk);
    chk("R7 cleared lines low", irq_o, 32'h7DA0_0000);
    rd(8, d); chk("R6 pass-through clear", d, 32'h7DA0_0000);
    wr(2, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 low lines stay low with summary", irq_o, 32'hFDA0_0000);
  endtask

  task automatic t_undef();
    logic [31:0] d;
    do_reset();
    src_i = 32'hFFFF_FFFF;
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    wr(10, 32'hFFFF_FFFF);
    wr(1023, 32'hFFFF_FFFF);
    rd(2, d); chk("R9 enable untouched by undefined writes", d, 32'h0);
    rd(8, d); chk("R9 pass-through untouched by undefined writes", d, 32'h0);
    chk("R9 outputs untouched by undefined writes", irq_o, 32'h0);
    wr(2, 32'h0000_F00F);
    wr(8, 32'h7FE0_0000);
    rd(3, d);    chk("R9 word3 reads zero", d, 32'h0);
    rd(5, d);    chk("R9 word5 reads zero", d, 32'h0);
    rd(9, d);    chk("R9 word9 reads zero", d, 32'h0);
    rd(6, d);    chk("R9 word6 reads zero", d, 32'h0);
    rd(1023, d); chk("R9 word1023 reads zero", d, 32'h0);
  endtask

  task automatic t_setup_only();
    logic [31:0] d;
    do_reset();
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = 12'h008; pwdata = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    rd(2, d); chk("R11 setup phase alone commits nothing", d, 32'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_raw();
    t_summary();
    t_bit0();
    t_passthru();
    t_undef();
    t_setup_only();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule